// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block gathers level-sensitive interrupt requests from devices on several expansion slots and turns them into the sixteen request lines of a legacy interrupt controller. Each device event arrives as a one-cycle strobe carrying the slot number, the device pin (A to D, coded 0 to 3) and the new level. A slot-dependent rotation folds that pin onto one of four shared request lines, and the block keeps the current level of each shared line in a flop.

Four route registers, one per shared line, are loaded through a single-cycle register-write port. Each register names the legacy IRQ line that its shared line drives, or holds a value that leaves the line unconnected. Several shared lines may name the same IRQ, in which case that IRQ is the OR of their levels. The IRQ outputs are formed combinationally from the stored levels and the route registers, so a change to either is seen at the outputs in the cycle right after the clock edge that captured it.

Top module: `irq_swizzle_router`

## Requirements
- R1: A request on slot S (0 to 31) and pin P (0 = A to 3 = D) updates shared line (P + S - 1) mod 4; slot 0 pin A lands on line 3.
- R2: When `req_valid` is high at a clock edge, the selected shared line takes `req_level` at that edge; the other three lines keep their levels.
- R3: While `rst_n` is low every stored shared-line level clears to 0 and the route registers take their preset values.
- R4: A write with `cfg_wr_en` high to address 0x60 + n (n = 0 to 3) loads the route register of shared line n at that clock edge; writes to any other address, and cycles with `cfg_wr_en` low, change no route register.
- R5: A route value of 16 or more (any of bits 7:4 set) makes the shared line drive no IRQ output; 15 still routes to IRQ 15.
- R6: Bit k of `irq_out` is the OR of the levels of all shared lines whose route register equals k; with all levels low `irq_out` is 0.
- R7: A route register write changes `irq_out` in the cycle after the write edge with no new device event.
- R8: With `PRESET` = `PRESET_ALL_OFF` every route register resets to 0x80; with `PRESET_SPLIT_10_11` lines 0 and 1 reset to 10 and lines 2 and 3 to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Device interrupt event strobe |
| req_slot | input | 5 | Slot number of the requesting device |
| req_pin | input | 2 | Device pin, 0 = A to 3 = D |
| req_level | input | 1 | New level of the device pin |
| cfg_wr_en | input | 1 | Route register write strobe |
| cfg_addr | input | 8 | Write address; 0x60 to 0x63 select the route registers |
| cfg_wr_data | input | 8 | Route value to load |
| irq_out | output | 16 | Legacy IRQ request lines |

## Verification
A wrong stored level or a wrong route value can only be seen through `irq_out`, and because that bus is a pure function of both, a corrupted flop shows on the output in the very next cycle, provided the affected line is both routed and asserted. The tests therefore give each shared line its own IRQ before sweeping slots and pins, so a mis-rotated request lights a distinguishable bit one cycle after its strobe. Stale or corrupted route registers are exposed by holding a level high and rewriting routes, including boundary values 15 and 16, and by writing neighbour addresses that must leave the output unchanged.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   typedef enum logic [0:0] {
      PRESET_ALL_OFF     = 1'b0,
      PRESET_SPLIT_10_11 = 1'b1
   } preset_e;

   localparam int unsigned ROUTE_OFF_VAL = 'h80;

   function automatic int unsigned route_preset(preset_e p, int unsigned line);
      if (p == PRESET_SPLIT_10_11)
         return (line < 2) ? 10 : 11;
      return ROUTE_OFF_VAL;
   endfunction

endpackage

// File: rtl/irq_swizzle.sv
module irq_swizzle #(
   parameter int unsigned SLOT_W     = 5,
   parameter int unsigned PIN_W      = 2,
   parameter int unsigned NUM_SHARED = 4,
   localparam int unsigned LINE_W    = $clog2(NUM_SHARED),
   localparam int unsigned SUM_W     = SLOT_W + 2
) (
   input  logic [SLOT_W-1:0] slot_i,
   input  logic [PIN_W-1:0]  pin_i,
   output logic [LINE_W-1:0] line_o
);

   logic [SUM_W-1:0] sum;

   // adding NUM_SHARED-1 is the same as subtracting one modulo NUM_SHARED
   always_comb begin
      sum    = SUM_W'(slot_i) + SUM_W'(pin_i) + SUM_W'(NUM_SHARED - 1);
      line_o = LINE_W'(sum % SUM_W'(NUM_SHARED));
   end

endmodule

// File: rtl/irq_level_store.sv
module irq_level_store #(
   parameter int unsigned NUM_SHARED = 4,
   localparam int unsigned LINE_W    = $clog2(NUM_SHARED)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  upd_en,
   input  logic [LINE_W-1:0]     upd_line,
   input  logic                  upd_level,
   output logic [NUM_SHARED-1:0] levels_o
);

   for (genvar i = 0; i < NUM_SHARED; i++) begin : g_line
      localparam logic [LINE_W-1:0] MY_LINE = LINE_W'(i);
      logic hit;
      assign hit = upd_en && (upd_line == MY_LINE);

      always_ff @(posedge clk) begin
         if (!rst_n)
            levels_o[i] <= 1'b0;
         else if (hit)
            levels_o[i] <= upd_level;
      end

      // R2: selected line takes the new level
      p_level_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (upd_en && upd_line == MY_LINE) |=> (levels_o[i] == $past(upd_level)));
      // R2: unselected line holds
      p_level_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !(upd_en && upd_line == MY_LINE) |=> $stable(levels_o[i]));
   end

   // R3: levels leave reset cleared
   p_reset_levels_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (levels_o == '0));

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irq_router_pkg::*;
#(
   parameter int unsigned NUM_SHARED = 4,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned ROUTE_W    = 8,
   parameter int unsigned ROUTE_BASE = 'h60,
   parameter preset_e     PRESET     = PRESET_ALL_OFF
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [ADDR_W-1:0]                    addr,
   input  logic [ROUTE_W-1:0]                   wdata,
   output logic [NUM_SHARED-1:0][ROUTE_W-1:0]   routes_o
);

   for (genvar i = 0; i < NUM_SHARED; i++) begin : g_reg
      localparam logic [ADDR_W-1:0]  MY_ADDR   = ADDR_W'(ROUTE_BASE + i);
      localparam logic [ROUTE_W-1:0] RESET_VAL = ROUTE_W'(route_preset(PRESET, i));
      logic sel;
      assign sel = wr_en && (addr == MY_ADDR);

      always_ff @(posedge clk) begin
         if (!rst_n)
            routes_o[i] <= RESET_VAL;
         else if (sel)
            routes_o[i] <= wdata;
      end

      // R4: a write to this register's address loads it
      p_route_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == MY_ADDR) |=> (routes_o[i] == $past(wdata)));
      // R4: any other cycle leaves it alone
      p_route_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && addr == MY_ADDR) |=> $stable(routes_o[i]));
      // R8: register leaves reset at its preset
      p_route_preset_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rst_n) |-> (routes_o[i] == RESET_VAL));
   end

endmodule

// File: rtl/irq_route_mux.sv
module irq_route_mux #(
   parameter int unsigned NUM_SHARED = 4,
   parameter int unsigned NUM_IRQ    = 16,
   parameter int unsigned ROUTE_W    = 8
) (
   input  logic [NUM_SHARED-1:0]               levels_i,
   input  logic [NUM_SHARED-1:0][ROUTE_W-1:0]  routes_i,
   output logic [NUM_IRQ-1:0]                  irq_o
);

   for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
      localparam logic [ROUTE_W-1:0] MY_IRQ = ROUTE_W'(k);
      logic [NUM_SHARED-1:0] hit;
      for (genvar j = 0; j < NUM_SHARED; j++) begin : g_src
         // values at or above NUM_IRQ never equal any MY_IRQ, so they route nowhere
         assign hit[j] = levels_i[j] && (routes_i[j] == MY_IRQ);
      end
      assign irq_o[k] = |hit;
   end

endmodule

// File: rtl/irq_swizzle_router.sv
module irq_swizzle_router
   import irq_router_pkg::*;
#(
   parameter int unsigned NUM_SHARED = 4,
   parameter int unsigned NUM_IRQ    = 16,
   parameter int unsigned SLOT_W     = 5,
   parameter int unsigned PIN_W      = 2,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned ROUTE_W    = 8,
   parameter int unsigned ROUTE_BASE = 'h60,
   parameter preset_e     PRESET     = PRESET_ALL_OFF,
   localparam int unsigned LINE_W    = $clog2(NUM_SHARED)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [SLOT_W-1:0]  req_slot,
   input  logic [PIN_W-1:0]   req_pin,
   input  logic               req_level,
   input  logic               cfg_wr_en,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [ROUTE_W-1:0] cfg_wr_data,
   output logic [NUM_IRQ-1:0] irq_out
);

   // elaboration-time parameter checks
   if (NUM_SHARED != (1 << PIN_W)) begin : g_chk_pins
      $error("NUM_SHARED must equal the number of device pins");
   end
   if (ROUTE_W < 8) begin : g_chk_route_w
      $error("ROUTE_W must hold the disabled preset value");
   end
   if (NUM_IRQ > (1 << ROUTE_W)) begin : g_chk_irq
      $error("NUM_IRQ not addressable by ROUTE_W");
   end
   if (ROUTE_BASE + NUM_SHARED > (1 << ADDR_W)) begin : g_chk_addr
      $error("route registers exceed address space");
   end

   logic [LINE_W-1:0]                  line_sel;
   logic [NUM_SHARED-1:0]              levels;
   logic [NUM_SHARED-1:0][ROUTE_W-1:0] routes;

   irq_swizzle #(
      .SLOT_W    (SLOT_W),
      .PIN_W     (PIN_W),
      .NUM_SHARED(NUM_SHARED)
   ) swz_i (
      .slot_i(req_slot),
      .pin_i (req_pin),
      .line_o(line_sel)
   );

   irq_level_store #(
      .NUM_SHARED(NUM_SHARED)
   ) lvl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (req_valid),
      .upd_line (line_sel),
      .upd_level(req_level),
      .levels_o (levels)
   );

   irq_route_regs #(
      .NUM_SHARED(NUM_SHARED),
      .ADDR_W    (ADDR_W),
      .ROUTE_W   (ROUTE_W),
      .ROUTE_BASE(ROUTE_BASE),
      .PRESET    (PRESET)
   ) rte_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .addr    (cfg_addr),
      .wdata   (cfg_wr_data),
      .routes_o(routes)
   );

   irq_route_mux #(
      .NUM_SHARED(NUM_SHARED),
      .NUM_IRQ   (NUM_IRQ),
      .ROUTE_W   (ROUTE_W)
   ) mux_i (
      .levels_i(levels),
      .routes_i(routes),
      .irq_o   (irq_out)
   );

   logic all_unrouted;
   always_comb begin
      all_unrouted = 1'b1;
      for (int j = 0; j < NUM_SHARED; j++)
         if (routes[j] < ROUTE_W'(NUM_IRQ)) all_unrouted = 1'b0;
   end

   // R5: nothing routed means no IRQ output can be active
   p_unrouted_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      all_unrouted |-> (irq_out == '0));
   // R6: no stored level means no IRQ output
   p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (levels == '0) |-> (irq_out == '0));
   // R6: the number of active IRQs never exceeds the number of active lines
   p_irq_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(irq_out) <= $countones(levels)));

endmodule

// File: tb/irq_swizzle_router_tb_top.sv
module irq_swizzle_router_tb_top;
   import irq_router_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [4:0]  req_slot = '0;
   logic [1:0]  req_pin = '0;
   logic        req_level = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [7:0]  cfg_wr_data = '0;
   logic [15:0] irq_out;
   logic [15:0] irq_preset;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   irq_swizzle_router dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slot(req_slot),
      .req_pin(req_pin), .req_level(req_level), .cfg_wr_en(cfg_wr_en),
      .cfg_addr(cfg_addr), .cfg_wr_data(cfg_wr_data), .irq_out(irq_out)
   );

   irq_swizzle_router #(.PRESET(PRESET_SPLIT_10_11)) dut_preset_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slot(req_slot),
      .req_pin(req_pin), .req_level(req_level), .cfg_wr_en(cfg_wr_en),
      .cfg_addr(cfg_addr), .cfg_wr_data(cfg_wr_data), .irq_out(irq_preset)
   );

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string what);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%04h expected=%04h", what, act, exp);
      end
   endtask

   task automatic send(input int slot, input int pin, input bit lvl);
      @(negedge clk);
      req_valid = 1'b1;
      req_slot  = 5'(slot);
      req_pin   = 2'(pin);
      req_level = lvl;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wr(input int addr, input int data, input bit en = 1'b1);
      @(negedge clk);
      cfg_wr_en   = en;
      cfg_addr    = 8'(addr);
      cfg_wr_data = 8'(data);
      @(negedge clk);
      cfg_wr_en   = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic int line_of(int slot, int pin);
      return (pin + slot + 3) % 4;
   endfunction

   task automatic t_reset_state();
      do_reset();
      chk(irq_out, 16'h0000, "R3 reset state");
      chk(irq_preset, 16'h0000, "R3 preset instance reset state");
   endtask

   task automatic t_preset_and_off();
      send(1, 0, 1'b1);   // slot1 pin A -> line 0
      chk(irq_preset, 16'h0400, "R8 preset line0 to IRQ10");
      chk(irq_out, 16'h0000, "R5 R8 default 0x80 routes nothing");
      send(1, 2, 1'b1);   // line 2
      chk(irq_preset, 16'h0C00, "R8 preset line2 to IRQ11");
      send(1, 0, 1'b0);
      send(1, 2, 1'b0);
      chk(irq_preset, 16'h0000, "R8 preset lines cleared");
   endtask

   task automatic t_swizzle();
      int slots[5] = '{0, 1, 2, 5, 31};
      for (int n = 0; n < 4; n++) wr('h60 + n, n + 1);
      foreach (slots[s]) begin
         for (int p = 0; p < 4; p++) begin
            send(slots[s], p, 1'b1);
            chk(irq_out, 16'(1 << (line_of(slots[s], p) + 1)),
                $sformatf("R1 R2 swizzle slot %0d pin %0d", slots[s], p));
            send(slots[s], p, 1'b0);
            chk(irq_out, 16'h0000, $sformatf("R2 deassert slot %0d pin %0d", slots[s], p));
         end
      end
      send(1, 0, 1'b1);   // line0 -> IRQ1
      send(1, 1, 1'b1);   // line1 -> IRQ2
      chk(irq_out, 16'h0006, "R2 other line keeps its level");
      send(1, 0, 1'b0);
      chk(irq_out, 16'h0004, "R2 clearing one line keeps the other");
      send(1, 1, 1'b0);
   endtask

   task automatic t_or_merge();
      wr('h60, 9);
      wr('h62, 9);
      wr('h61, 3);
      send(1, 0, 1'b1);
      send(1, 2, 1'b1);
      chk(irq_out, 16'h0200, "R6 two lines onto IRQ9");
      send(1, 1, 1'b1);
      chk(irq_out, 16'h0208, "R6 separate IRQ3 alongside");
      send(1, 0, 1'b0);
      chk(irq_out, 16'h0208, "R6 IRQ9 held by remaining line");
      send(1, 2, 1'b0);
      send(1, 1, 1'b0);
      chk(irq_out, 16'h0000, "R6 all lines low");
   endtask

   task automatic t_route_live();
      send(1, 0, 1'b1);   // line0 high, routed to 9
      chk(irq_out, 16'h0200, "R7 before rewrite");
      wr('h60, 4);
      chk(irq_out, 16'h0010, "R7 rewrite moves output next cycle");
      wr('h60, 16);
      chk(irq_out, 16'h0000, "R5 value 16 unrouted");
      wr('h60, 'hFF);
      chk(irq_out, 16'h0000, "R5 value 0xFF unrouted");
      wr('h60, 15);
      chk(irq_out, 16'h8000, "R5 value 15 still routes");
   endtask

   task automatic t_ignored_writes();
      wr('h64, 3);
      chk(irq_out, 16'h8000, "R4 write to 0x64 ignored");
      wr('h5F, 3);
      chk(irq_out, 16'h8000, "R4 write to 0x5F ignored");
      wr('h60, 3, 1'b0);
      chk(irq_out, 16'h8000, "R4 disabled write ignored");
      wr('h60, 0);
      chk(irq_out, 16'h0001, "R4 write to 0x60 routes line0 to IRQ0");
   endtask

   task automatic t_reset_midrun();
      send(1, 1, 1'b1);
      do_reset();
      chk(irq_out, 16'h0000, "R3 reset mid-run");
      wr('h60, 5);
      wr('h61, 6);
      chk(irq_out, 16'h0000, "R3 levels cleared by reset");
      send(1, 1, 1'b1);
      chk(irq_out, 16'h0040, "R3 R2 level usable after reset");
   endtask

   initial begin
      t_reset_state();
      t_preset_and_off();
      t_swizzle();
      t_or_merge();
      t_route_live();
      t_ignored_writes();
      t_reset_midrun();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog all requirements actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule